// File: doc/BRIEF.md
# Per-Vector Interrupt Message Table

This block holds a table of interrupt vectors. Every entry has a 64-bit target address, a 32-bit data word and a mask bit. Software reaches the entries through a simple word-wide register port. A peripheral raises a request on one of the per-vector request lines. If that vector and the whole function are unmasked, the block turns the request into one memory-write message on its output handshake. The message carries the entry's address, its data and its vector index. Because every vector has its own address and data, vectors can be steered to different processors.

A request for a masked vector is not lost. It is recorded as a pending bit, which software can read, and the message goes out once the vector is unmasked. A single function-wide mask input holds back every message while keeping all pending state. When several vectors wait at once, they are served in round-robin order, so no vector is starved. The address and data are taken from the table in the cycle the message is launched. An entry rewritten while its vector waits therefore sends the new contents.

Top module: `irq_vector_table`

## Requirements
- R1: After reset every entry has address 0, data 0 and mask set. No vector is pending, the register read word is 0 and `msg_valid` is low.
- R2: Register field codes on `reg_field` are 0 = address bits 31:0, 1 = address bits 63:32, 2 = data word and 3 = control. In the control word, bit 0 is the mask (read/write) and bit 1 is the pending flag (read-only). A write takes effect at the clock edge where `reg_wr` is high. A read sampled at an edge with `reg_rd` high shows on `reg_rdata` after that edge, with the state from before it, and `reg_rdata` holds until the next read.
- R3: A request sampled at edge k on an unmasked vector, with the output free, gives `msg_valid` high after edge k+1. The message carries that entry's address, data and index in `msg_vec`.
- R4: While `msg_valid` is high and `msg_ready` is low, the message stays unchanged. A new message may launch at the same edge that completes a handshake.
- R5: A request on a masked vector sets its pending flag and sends nothing. Once the vector is unmasked, the message is launched.
- R6: While `func_mask` is high no message is launched. Pending flags keep their state and are served after the mask drops.
- R7: A vector's pending flag clears at the edge that launches its message. A request for the same vector sampled at that edge sets the flag again.
- R8: Among launchable vectors the one chosen is the first found searching upward, wrapping, from the vector after the last launched one. After reset the search starts at vector 0.
- R9: A message takes the entry's address and data as they stand at its launch edge. Edits made while the vector waits are therefore sent.
- R10: Several requests for one vector while it is already pending produce a single message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N | Per-vector request pulses |
| func_mask | input | 1 | Holds back all messages |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_vec | input | $clog2(N) | Vector index for register access |
| reg_field | input | 2 | Field code (see R2) |
| reg_wdata | input | 32 | Register write word |
| reg_rdata | output | 32 | Registered read word |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message data word |
| msg_vec | output | $clog2(N) | Index of the vector sent |

## Verification
A request sampled at one edge shows as a message after the next edge. A read strobe shows its word after the edge that samples it. Pending flags and masks change at the edge where they are sampled.

The bench keeps a behavioural model that advances at each rising edge on the same inputs. It compares every output half a period later, so each result is checked in the cycle it becomes due.

Handshakes are logged at the falling edge, after `msg_ready` has been driven. The directed checks compare the order and contents of the messages against fixed expected lists.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    FLD_ADDR_LO = 2'd0,
    FLD_ADDR_HI = 2'd1,
    FLD_DATA    = 2'd2,
    FLD_CTRL    = 2'd3
  } ivt_field_e;

  // Replace one 32-bit half of a 64-bit address.
  function automatic logic [ADDR_W-1:0] merge_addr(input logic [ADDR_W-1:0] old,
                                                   input logic hi,
                                                   input logic [WORD_W-1:0] w);
    merge_addr = hi ? {w, old[WORD_W-1:0]} : {old[ADDR_W-1:WORD_W], w};
  endfunction

  // Control word: bit1 pending (read-only), bit0 mask.
  function automatic logic [WORD_W-1:0] ctrl_word(input logic pend, input logic mask);
    ctrl_word = {{(WORD_W-2){1'b0}}, pend, mask};
  endfunction
endpackage

// File: rtl/ivt_table.sv
module ivt_table
  import ivt_pkg::*;
#(
  parameter int N      = 64,
  parameter int DATA_W = 32,
  parameter int IW     = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [1:0]          wr_fld,
  input  logic [WORD_W-1:0]   wr_word,
  output logic [N-1:0]        mask_o,
  input  logic [IW-1:0]       a_idx,
  output logic [ADDR_W-1:0]   a_addr,
  output logic [DATA_W-1:0]   a_data,
  input  logic [IW-1:0]       b_idx,
  output logic [ADDR_W-1:0]   b_addr,
  output logic [DATA_W-1:0]   b_data
);
  logic [ADDR_W-1:0] addr_q [N];
  logic [DATA_W-1:0] data_q [N];
  logic [N-1:0]      mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
      mask_q <= '1;
    end else if (wr_en) begin
      case (ivt_field_e'(wr_fld))
        FLD_ADDR_LO: addr_q[wr_idx] <= merge_addr(addr_q[wr_idx], 1'b0, wr_word);
        FLD_ADDR_HI: addr_q[wr_idx] <= merge_addr(addr_q[wr_idx], 1'b1, wr_word);
        FLD_DATA:    data_q[wr_idx] <= DATA_W'(wr_word);
        FLD_CTRL:    mask_q[wr_idx] <= wr_word[0];
        default: ;
      endcase
    end
  end

  assign mask_o = mask_q;
  assign a_addr = addr_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_addr = addr_q[b_idx];
  assign b_data = data_q[b_idx];
endmodule

// File: rtl/ivt_pending.sv
module ivt_pending #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_i,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hit;
    assign hit = clr_en && (clr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_o[g] <= 1'b0;
      else if (set_i[g]) pend_o[g] <= 1'b1;   // new request wins over clear
      else if (hit)      pend_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/ivt_rr_arb.sv
module ivt_rr_arb #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic          grant_ok,
  output logic [IW-1:0] grant_idx
);
  logic [IW-1:0] last_q;

  // First set bit searching upward from last+1, wrapping.
  function automatic logic [IW:0] rr_pick(input logic [N-1:0] r, input logic [IW-1:0] last);
    logic [IW:0] res;
    res = '0;
    for (int i = 1; i <= N; i++) begin
      int idx;
      idx = (int'(last) + i) % N;
      if (!res[IW] && r[idx]) res = {1'b1, IW'(idx)};
    end
    return res;
  endfunction

  always_comb {grant_ok, grant_idx} = rr_pick(req, last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= IW'(N - 1);
    else if (advance) last_q <= grant_idx;
  end
endmodule

// File: rtl/irq_vector_table.sv
module irq_vector_table
  import ivt_pkg::*;
#(
  parameter int N      = 64,
  parameter int DATA_W = 32,
  localparam int IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_req,
  input  logic              func_mask,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [IW-1:0]     reg_vec,
  input  logic [1:0]        reg_field,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data,
  output logic [IW-1:0]     msg_vec
);
  // Named internal events, observed by the bound checker.
  logic [N-1:0]      mask_vec;
  logic [N-1:0]      pending;
  logic [N-1:0]      eligible;
  logic              grant_ok;
  logic [IW-1:0]     grant_idx;
  logic              out_free;
  logic              launch;
  logic [ADDR_W-1:0] rv_addr, g_addr;
  logic [DATA_W-1:0] rv_data, g_data;

  ivt_table #(.N(N), .DATA_W(DATA_W), .IW(IW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_idx(reg_vec), .wr_fld(reg_field), .wr_word(reg_wdata),
    .mask_o(mask_vec),
    .a_idx(reg_vec), .a_addr(rv_addr), .a_data(rv_data),
    .b_idx(grant_idx), .b_addr(g_addr), .b_data(g_data)
  );

  ivt_pending #(.N(N), .IW(IW)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_i(irq_req), .clr_en(launch), .clr_idx(grant_idx),
    .pend_o(pending)
  );

  assign eligible = pending & ~mask_vec & {N{~func_mask}};

  ivt_rr_arb #(.N(N), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req(eligible), .advance(launch),
    .grant_ok(grant_ok), .grant_idx(grant_idx)
  );

  assign out_free = !msg_valid || msg_ready;
  assign launch   = grant_ok && out_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_vec   <= '0;
    end else if (launch) begin
      msg_valid <= 1'b1;
      msg_addr  <= g_addr;
      msg_data  <= g_data;
      msg_vec   <= grant_idx;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (ivt_field_e'(reg_field))
        FLD_ADDR_LO: reg_rdata <= rv_addr[WORD_W-1:0];
        FLD_ADDR_HI: reg_rdata <= rv_addr[ADDR_W-1:WORD_W];
        FLD_DATA:    reg_rdata <= WORD_W'(rv_data);
        default:     reg_rdata <= ctrl_word(pending[reg_vec], mask_vec[reg_vec]);
      endcase
    end
  end
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
  parameter int N      = 64,
  parameter int DATA_W = 32,
  parameter int IW     = $clog2(N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      irq_req,
  input logic              func_mask,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [63:0]       msg_addr,
  input logic [DATA_W-1:0] msg_data,
  input logic [IW-1:0]     msg_vec,
  input logic              launch,
  input logic [IW-1:0]     grant_idx,
  input logic [N-1:0]      pending,
  input logic [N-1:0]      mask_vec
);
  // R4
  hold_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_vec));

  // R3
  launch_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> msg_valid && (msg_vec == $past(grant_idx)));

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !mask_vec[grant_idx] && pending[grant_idx]);

  // R6
  func_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    func_mask |-> !launch);

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch && !irq_req[grant_idx] |=> !pending[$past(grant_idx)]);
endmodule

bind irq_vector_table ivt_chk #(.N(N), .DATA_W(DATA_W), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .func_mask(func_mask),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data), .msg_vec(msg_vec), .launch(launch),
  .grant_idx(grant_idx), .pending(pending), .mask_vec(mask_vec)
);

// File: tb/tb_irq_vector_table.sv
module tb_irq_vector_table;
  localparam int N  = 64;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic          func_mask = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [IW-1:0] reg_vec = '0;
  logic [1:0]    reg_field = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          msg_valid, msg_ready = 1'b1;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;
  logic [IW-1:0] msg_vec;

  irq_vector_table #(.N(N)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int hs_vec[$];
  logic [63:0] hs_addr[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [63:0] m_addr [N];
  logic [31:0] m_data [N];
  bit m_mask [N];
  bit m_pend [N];
  int m_ptr;
  bit m_valid;
  logic [63:0] m_oaddr;
  logic [31:0] m_odata, m_rdata;
  int m_ovec;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < N; v++) begin
        m_addr[v] = 0; m_data[v] = 0; m_mask[v] = 1; m_pend[v] = 0;
      end
      m_ptr = N - 1; m_valid = 0; m_oaddr = 0; m_odata = 0; m_ovec = 0; m_rdata = 0;
    end else begin
      int win;
      win = -1;
      if ((!m_valid || msg_ready) && !func_mask)
        for (int i = 1; i <= N; i++) begin
          int idx;
          idx = (m_ptr + i) % N;
          if (win < 0 && m_pend[idx] && !m_mask[idx]) win = idx;
        end
      if (reg_rd)
        case (reg_field)
          2'd0: m_rdata = m_addr[reg_vec][31:0];
          2'd1: m_rdata = m_addr[reg_vec][63:32];
          2'd2: m_rdata = m_data[reg_vec];
          default: m_rdata = {30'd0, m_pend[reg_vec], m_mask[reg_vec]};
        endcase
      if (win >= 0) begin
        m_valid = 1; m_oaddr = m_addr[win]; m_odata = m_data[win];
        m_ovec = win; m_ptr = win; m_pend[win] = 0;
      end else if (m_valid && msg_ready) m_valid = 0;
      for (int v = 0; v < N; v++) if (irq_req[v]) m_pend[v] = 1;
      if (reg_wr)
        case (reg_field)
          2'd0: m_addr[reg_vec][31:0] = reg_wdata;
          2'd1: m_addr[reg_vec][63:32] = reg_wdata;
          2'd2: m_data[reg_vec] = reg_wdata;
          default: m_mask[reg_vec] = reg_wdata[0];
        endcase
    end
  end

  // Compare every cycle, away from the rising edge, after inputs settle.
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R3 msg_valid", 64'(msg_valid), 64'(m_valid));
      chk("R2 reg_rdata", 64'(reg_rdata), 64'(m_rdata));
      if (m_valid) begin
        chk("R9 msg_addr", msg_addr, m_oaddr);
        chk("R3 msg_data", 64'(msg_data), 64'(m_odata));
        chk("R8 msg_vec", 64'(msg_vec), 64'(m_ovec));
      end
      if (msg_valid && msg_ready) begin
        hs_vec.push_back(int'(msg_vec));
        hs_addr.push_back(msg_addr);
      end
    end
  end

  task automatic nxt();
    @(negedge clk);
    irq_req = '0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic wr(input int v, input int f, input logic [31:0] d);
    nxt(); reg_wr = 1; reg_vec = IW'(v); reg_field = 2'(f); reg_wdata = d;
  endtask

  task automatic rd_chk(input int v, input int f, input logic [31:0] exp, input string tag);
    nxt(); reg_rd = 1; reg_vec = IW'(v); reg_field = 2'(f);
    nxt(); #2;
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) nxt();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    #2 chk("R1 msg_valid after reset", 64'(msg_valid), 64'd0);
    rd_chk(5, 3, 32'd1, "R1 ctrl masked after reset");
    rd_chk(5, 0, 32'd0, "R1 address zero after reset");

    // R2: program entries
    for (int v = 0; v < 16; v++) begin
      wr(v, 0, 32'h1000_0000 | (v << 4));
      wr(v, 1, 32'hF000_0000 + v);
      wr(v, 2, 32'hD000_0000 + v);
      wr(v, 3, (v == 7 || v == 10) ? 32'd1 : 32'd0);
    end
    rd_chk(9, 1, 32'hF000_0009, "R2 address high readback");
    rd_chk(9, 2, 32'hD000_0009, "R2 data readback");

    // R3: single request
    hs_vec.delete(); hs_addr.delete();
    nxt(); irq_req[3] = 1;
    idle(4);
    chk("R3 one message", 64'(hs_vec.size()), 64'd1);
    if (hs_vec.size() == 1) chk("R3 address", hs_addr[0], 64'hF000_0003_1000_0030);

    // R4/R8: backpressure and round robin after vector 3
    hs_vec.delete(); hs_addr.delete();
    nxt(); msg_ready = 0; irq_req[1] = 1; irq_req[4] = 1; irq_req[6] = 1;
    idle(5);
    msg_ready = 1;
    idle(6);
    chk("R8 count", 64'(hs_vec.size()), 64'd3);
    if (hs_vec.size() == 3) begin
      chk("R8 first", 64'(hs_vec[0]), 64'd4);
      chk("R8 second", 64'(hs_vec[1]), 64'd6);
      chk("R8 wrap", 64'(hs_vec[2]), 64'd1);
    end

    // R5/R9: masked request, edit while pending, then unmask
    hs_vec.delete(); hs_addr.delete();
    nxt(); irq_req[10] = 1;
    idle(4);
    chk("R5 nothing sent while masked", 64'(hs_vec.size()), 64'd0);
    rd_chk(10, 3, 32'd3, "R5 pending and masked");
    wr(10, 0, 32'hCAFE_0000);
    wr(10, 3, 32'd0);
    idle(4);
    chk("R5 sent after unmask", 64'(hs_vec.size()), 64'd1);
    if (hs_addr.size() == 1) chk("R9 new address used", hs_addr[0], 64'hF000_000A_CAFE_0000);

    // R10: repeated requests merge
    hs_vec.delete(); hs_addr.delete();
    for (int k = 0; k < 3; k++) begin nxt(); irq_req[7] = 1; nxt(); end
    wr(7, 3, 32'd0);
    idle(5);
    chk("R10 single merged message", 64'(hs_vec.size()), 64'd1);

    // R6/R7: function mask, then pending clear
    hs_vec.delete(); hs_addr.delete();
    nxt(); func_mask = 1; irq_req[2] = 1;
    idle(5);
    chk("R6 held by function mask", 64'(hs_vec.size()), 64'd0);
    rd_chk(2, 3, 32'd2, "R6 pending kept");
    nxt(); func_mask = 0;
    idle(4);
    chk("R6 sent after release", 64'(hs_vec.size()), 64'd1);
    rd_chk(2, 3, 32'd0, "R7 pending cleared");

    // Random traffic, compared cycle by cycle against the model
    for (int c = 0; c < 3000; c++) begin
      nxt();
      irq_req = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
              & {$urandom, $urandom} & {$urandom, $urandom};
      msg_ready = ($urandom % 4) != 0;
      if ($urandom % 50 == 0) func_mask = ~func_mask;
      if ($urandom % 3 == 0) begin
        reg_wr = 1; reg_vec = IW'($urandom); reg_field = 2'($urandom);
        reg_wdata = (reg_field == 2'd3) ? 32'($urandom % 4 == 0) : $urandom;
      end
      if ($urandom % 3 == 0) begin
        reg_rd = 1; if (!reg_wr) begin reg_vec = IW'($urandom); reg_field = 2'($urandom); end
      end
    end
    func_mask = 0; msg_ready = 1;
    idle(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule